// File: doc/BRIEF.md
# Debug Trigger and Breakpoint Controller

This block sits beside an on-chip debugger's comparators and trace memory. It decides what a debug trigger does to trace capture and whether the CPU gets a breakpoint request. A trigger comes either from a comparator match or from a forced-trigger bit. Depending on the trace-enable and alignment settings, the trigger either opens a capture window or closes one, or it skips tracing and asks for a breakpoint at once.

Each breakpoint is held as a pending request until it can be delivered. It is then routed to one of two outputs: a software-interrupt breakpoint or an entry into background-debug mode. Routing follows the breakpoint-enable bit, the route-to-debug bit, and the enable and activity state of the debug mode. A request that arrives while debug mode is active is kept and delivered once normal flow resumes. Clearing the arm bit drops everything.

All outputs are registered. A stimulus presented in one cycle shows at the ports after the next rising edge.

Top module: `dbg_brk_ctrl`

## Requirements
- R1: With tracing enabled and begin alignment (`trig_at_end`=0), a trigger while waiting pulses `trace_start` and gives no breakpoint. A later `buf_full` pulses `trace_stop` and delivers the breakpoint on the same edge.
- R2: With tracing enabled and end alignment (`trig_at_end`=1), a trigger while waiting pulses `trace_stop` and delivers the breakpoint on the same edge, with no `trace_start`.
- R3: With `brk_en`=0 a trigger still acts on the trace strobes, but neither `brk_swi` nor `brk_bgd` is ever raised.
- R4: With `trace_en`=0 a trigger delivers a breakpoint on the next edge and produces no trace strobe.
- R5: Raising `arm` and `force_trig` in the same cycle, starting from disarmed, acts as a forced trigger.
- R6: Once capture has started or the trigger has been consumed, further `cmp_hit` or `force_trig` pulses produce no strobe and no breakpoint.
- R7: `cmp_hit` is ignored while `bgd_active`=1. `force_trig` is not blocked by it.
- R8: Routing of a breakpoint:
  - `brk_en`=0 gives none.
  - `to_bgd`=0 gives `brk_swi`.
  - `to_bgd`=1 with `bgd_enabled`=0 gives `brk_swi`.
  - `to_bgd`=1 with `bgd_enabled`=1 and `bgd_active`=0 gives `brk_bgd`.
- R9: While `bgd_active`=1 no breakpoint is delivered. A pending one is delivered on the edge after the first cycle with `bgd_active`=0.
- R10: When `user_swi`=1 in the cycle a breakpoint resolves, a debug-mode breakpoint is still delivered. A software-interrupt breakpoint waits until `user_swi`=0.
- R11: After reset, and on the edge after any cycle with `arm`=0, all outputs are 0, capture state returns to waiting and any pending breakpoint is discarded.
- R12: `brk_swi` and `brk_bgd` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| arm | input | 1 | Arms the controller; low returns it to waiting |
| force_trig | input | 1 | Forced trigger request |
| trace_en | input | 1 | Trace capture tied to the trigger |
| trig_at_end | input | 1 | 1: trigger ends capture; 0: trigger begins capture |
| cmp_hit | input | 1 | Comparator match pulse |
| buf_full | input | 1 | Trace memory has filled |
| brk_en | input | 1 | Breakpoints allowed |
| to_bgd | input | 1 | Prefer background-debug entry over software interrupt |
| bgd_enabled | input | 1 | Background-debug mode is enabled |
| bgd_active | input | 1 | CPU is running in background-debug mode |
| user_swi | input | 1 | CPU is at a user software-interrupt instruction |
| trace_start | output | 1 | Capture start strobe |
| trace_stop | output | 1 | Capture stop strobe |
| brk_swi | output | 1 | Software-interrupt breakpoint request pulse |
| brk_bgd | output | 1 | Background-debug entry request pulse |

## Verification
A stuck or wrong capture state shows up as a missing `trace_start` or a premature `trace_stop`. It can also show as a second breakpoint from a late trigger, one edge after the offending stimulus. A lost or stale pending flag shows later: a breakpoint that never comes after `bgd_active` or `user_swi` falls, or one that appears after re-arming. The bench therefore checks the cycle right after each release as well as the trigger cycle. It also compares all four outputs with an independent model on every edge, so any divergence is reported in the cycle it occurs.

// File: rtl/dbg_brk_pkg.sv
package dbg_brk_pkg;

    typedef enum logic [1:0] {
        SEQ_WAIT    = 2'd0,
        SEQ_CAPTURE = 2'd1,
        SEQ_DONE    = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        RT_NONE = 2'd0,
        RT_SWI  = 2'd1,
        RT_BGD  = 2'd2
    } route_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic brk;
    } trig_evt_t;

    // Destination of a breakpoint under the current debug configuration
    function automatic route_e resolve_route(
        input logic brk_en,
        input logic to_bgd,
        input logic bgd_enabled,
        input logic bgd_active
    );
        if (!brk_en || bgd_active)
            return RT_NONE;
        else if (to_bgd && bgd_enabled)
            return RT_BGD;
        else
            return RT_SWI;
    endfunction

endpackage

// File: rtl/dbg_trig_seq.sv
module dbg_trig_seq
    import dbg_brk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic force_trig,
    input  logic cmp_hit,
    input  logic bgd_active,
    input  logic trace_en,
    input  logic trig_at_end,
    input  logic buf_full,
    output logic trace_start,
    output logic trace_stop,
    output logic brk_evt
);

    seq_state_e st, st_nx;
    trig_evt_t  evt;
    logic       hit;

    always_comb begin
        hit   = force_trig | (cmp_hit & ~bgd_active);
        st_nx = st;
        evt   = '0;
        case (st)
            SEQ_WAIT: begin
                if (hit) begin
                    if (!trace_en) begin
                        st_nx   = SEQ_DONE;
                        evt.brk = 1'b1;
                    end else if (!trig_at_end) begin
                        st_nx     = SEQ_CAPTURE;
                        evt.start = 1'b1;
                    end else begin
                        st_nx    = SEQ_DONE;
                        evt.stop = 1'b1;
                        evt.brk  = 1'b1;
                    end
                end
            end
            SEQ_CAPTURE: begin
                if (buf_full) begin
                    st_nx    = SEQ_DONE;
                    evt.stop = 1'b1;
                    evt.brk  = 1'b1;
                end
            end
            default: ;
        endcase
        if (!arm) begin
            st_nx = SEQ_WAIT;
            evt   = '0;
        end
    end

    assign brk_evt = evt.brk;

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= SEQ_WAIT;
            trace_start <= 1'b0;
            trace_stop  <= 1'b0;
        end else begin
            st          <= st_nx;
            trace_start <= evt.start;
            trace_stop  <= evt.stop;
        end
    end

    // R6: a running capture never restarts
    p_no_restart_r6: assert property (@(posedge clk) disable iff (rst)
        (st == SEQ_CAPTURE) |=> !trace_start);

    // R1: capture only stops when the buffer fills
    p_hold_capture_r1: assert property (@(posedge clk) disable iff (rst)
        (st == SEQ_CAPTURE && arm && !buf_full) |=> !trace_stop);

    // R7: comparator matches do not leave the waiting state during debug mode
    p_cmp_masked_r7: assert property (@(posedge clk) disable iff (rst)
        (st == SEQ_WAIT && arm && bgd_active && !force_trig) |=> (st == SEQ_WAIT));

    // R11: disarming silences the strobes
    p_disarm_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !arm |=> (!trace_start && !trace_stop && st == SEQ_WAIT));

endmodule

// File: rtl/dbg_brk_route.sv
module dbg_brk_route
    import dbg_brk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic brk_evt,
    input  logic brk_en,
    input  logic to_bgd,
    input  logic bgd_enabled,
    input  logic bgd_active,
    input  logic user_swi,
    output logic brk_swi,
    output logic brk_bgd
);

    route_e rt;
    logic   pend, pend_now, pend_nx;
    logic   swi_nx, bgd_nx;

    always_comb begin
        rt       = resolve_route(brk_en, to_bgd, bgd_enabled, bgd_active);
        pend_now = pend | (brk_evt & brk_en);
        pend_nx  = pend_now;
        swi_nx   = 1'b0;
        bgd_nx   = 1'b0;
        if (!arm) begin
            pend_nx = 1'b0;
        end else begin
            case (rt)
                RT_BGD: begin
                    if (pend_now) begin
                        bgd_nx  = 1'b1;
                        pend_nx = 1'b0;
                    end
                end
                RT_SWI: begin
                    if (pend_now && !user_swi) begin
                        swi_nx  = 1'b1;
                        pend_nx = 1'b0;
                    end
                end
                default: begin
                    if (!brk_en)
                        pend_nx = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend    <= 1'b0;
            brk_swi <= 1'b0;
            brk_bgd <= 1'b0;
        end else begin
            pend    <= pend_nx;
            brk_swi <= swi_nx;
            brk_bgd <= bgd_nx;
        end
    end

    // R12: the two requests are exclusive
    p_exclusive_r12: assert property (@(posedge clk) disable iff (rst)
        !(brk_swi && brk_bgd));

    // R12: each request lasts one cycle
    p_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        (brk_swi || brk_bgd) |=> (!brk_swi && !brk_bgd));

    // R9: nothing is delivered while debug mode runs
    p_quiet_active_r9: assert property (@(posedge clk) disable iff (rst)
        bgd_active |=> (!brk_swi && !brk_bgd));

    // R3: disabled breakpoints never reach the outputs
    p_disabled_r3: assert property (@(posedge clk) disable iff (rst)
        !brk_en |=> (!brk_swi && !brk_bgd));

    // R10: a user software interrupt holds back the software breakpoint
    p_swi_defer_r10: assert property (@(posedge clk) disable iff (rst)
        user_swi |=> !brk_swi);

    // R11: disarming drops any pending request
    p_disarm_clear_r11: assert property (@(posedge clk) disable iff (rst)
        !arm |=> (!pend && !brk_swi && !brk_bgd));

endmodule

// File: rtl/dbg_brk_ctrl.sv
module dbg_brk_ctrl
    import dbg_brk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic force_trig,
    input  logic trace_en,
    input  logic trig_at_end,
    input  logic cmp_hit,
    input  logic buf_full,
    input  logic brk_en,
    input  logic to_bgd,
    input  logic bgd_enabled,
    input  logic bgd_active,
    input  logic user_swi,
    output logic trace_start,
    output logic trace_stop,
    output logic brk_swi,
    output logic brk_bgd
);

    logic brk_evt;

    dbg_trig_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .arm         (arm),
        .force_trig  (force_trig),
        .cmp_hit     (cmp_hit),
        .bgd_active  (bgd_active),
        .trace_en    (trace_en),
        .trig_at_end (trig_at_end),
        .buf_full    (buf_full),
        .trace_start (trace_start),
        .trace_stop  (trace_stop),
        .brk_evt     (brk_evt)
    );

    dbg_brk_route u_route (
        .clk         (clk),
        .rst         (rst),
        .arm         (arm),
        .brk_evt     (brk_evt),
        .brk_en      (brk_en),
        .to_bgd      (to_bgd),
        .bgd_enabled (bgd_enabled),
        .bgd_active  (bgd_active),
        .user_swi    (user_swi),
        .brk_swi     (brk_swi),
        .brk_bgd     (brk_bgd)
    );

    // R2/R12: a stop strobe with a delivered breakpoint never carries a start
    p_stop_start_r2: assert property (@(posedge clk) disable iff (rst)
        (trace_stop && (brk_swi || brk_bgd)) |-> !trace_start);

endmodule

// File: tb/sim_dbg_brk_ctrl.sv
`timescale 1ns/1ps
module sim_dbg_brk_ctrl;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic arm = 0, force_trig = 0, trace_en = 0, trig_at_end = 0, cmp_hit = 0;
    logic buf_full = 0, brk_en = 0, to_bgd = 0, bgd_enabled = 0, bgd_active = 0, user_swi = 0;
    logic trace_start, trace_stop, brk_swi, brk_bgd;

    always #2 clk = ~clk;

    dbg_brk_ctrl u0 (
        .clk(clk), .rst(rst), .arm(arm), .force_trig(force_trig),
        .trace_en(trace_en), .trig_at_end(trig_at_end), .cmp_hit(cmp_hit),
        .buf_full(buf_full), .brk_en(brk_en), .to_bgd(to_bgd),
        .bgd_enabled(bgd_enabled), .bgd_active(bgd_active), .user_swi(user_swi),
        .trace_start(trace_start), .trace_stop(trace_stop),
        .brk_swi(brk_swi), .brk_bgd(brk_bgd)
    );

    int    n_chk = 0;
    int    n_err = 0;
    bit    done  = 0;
    bit    live  = 0;
    string cur_req = "R11";

    // Behavioural reference: phase 0 waiting, 1 capturing, 2 consumed
    int       m_phase = 0;
    bit       m_owed  = 0;
    bit [3:0] m_out   = 4'b0;

    always @(posedge clk) begin
        bit fire, want_brk;
        bit [3:0] o;
        o = 4'b0;
        if (rst || !arm) begin
            m_phase = 0;
            m_owed  = 0;
        end else begin
            fire = force_trig || (cmp_hit && !bgd_active);
            want_brk = 0;
            if (m_phase == 0 && fire) begin
                if (!trace_en)         begin m_phase = 2; want_brk = 1; end
                else if (trig_at_end)  begin m_phase = 2; o[2] = 1; want_brk = 1; end
                else                   begin m_phase = 1; o[3] = 1; end
            end else if (m_phase == 1 && buf_full) begin
                m_phase = 2; o[2] = 1; want_brk = 1;
            end
            if (want_brk && brk_en) m_owed = 1;
            if (!brk_en) m_owed = 0;
            else if (m_owed && !bgd_active) begin
                if (to_bgd && bgd_enabled) begin o[0] = 1; m_owed = 0; end
                else if (!user_swi)        begin o[1] = 1; m_owed = 0; end
            end
        end
        m_out = o;
    end

    function automatic bit [3:0] outs();
        return {trace_start, trace_stop, brk_swi, brk_bgd};
    endfunction

    task automatic chk(input string req, input bit [3:0] exp);
        n_chk++;
        if (outs() !== exp) begin
            n_err++;
            $display("FAIL %s: {start,stop,swi,bgd} actual=%b expected=%b at %0t",
                     req, outs(), exp, $time);
        end
    endtask

    // Model comparison every cycle
    always @(negedge clk) begin
        if (live && !done) begin
            n_chk++;
            if (outs() !== m_out) begin
                n_err++;
                $display("FAIL %s (model): actual=%b expected=%b at %0t",
                         cur_req, outs(), m_out, $time);
            end
        end
    end

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic disarm();
        arm = 0; force_trig = 0; cmp_hit = 0; buf_full = 0;
        bgd_active = 0; user_swi = 0;
        tick(); tick();
    endtask

    // Pulse one trigger source for a cycle, then look at the result
    task automatic pulse_force();
        force_trig = 1; tick(); force_trig = 0;
    endtask
    task automatic pulse_cmp();
        cmp_hit = 1; tick(); cmp_hit = 0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=running expected=finished");
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        tick(2);
        chk("R11 reset", 4'b0000);
        rst = 0;
        live = 1;
        tick();

        // R1 begin alignment
        cur_req = "R1";
        arm = 1; trace_en = 1; trig_at_end = 0; brk_en = 1; to_bgd = 0;
        tick();
        pulse_cmp();   chk("R1 start", 4'b1000);
        tick(3);       chk("R1 no early brk", 4'b0000);
        cur_req = "R6";
        pulse_force(); chk("R6 force in capture", 4'b0000);
        pulse_cmp();   chk("R6 cmp in capture", 4'b0000);
        cur_req = "R1";
        buf_full = 1; tick(); buf_full = 0;
        chk("R1 stop+brk", 4'b0110);
        tick();        chk("R12 one pulse", 4'b0000);
        cur_req = "R6";
        pulse_force(); chk("R6 after done", 4'b0000);
        disarm();

        // R2 end alignment to debug entry
        cur_req = "R2";
        arm = 1; trig_at_end = 1; to_bgd = 1; bgd_enabled = 1;
        tick();
        pulse_force(); chk("R2 stop+bgd", 4'b0101);
        disarm();

        // R3 breakpoints disabled
        cur_req = "R3";
        arm = 1; brk_en = 0;
        tick();
        pulse_force(); chk("R3 stop only", 4'b0100);
        tick(2);       chk("R3 nothing later", 4'b0000);
        disarm();

        // R4 no tracing
        cur_req = "R4";
        arm = 1; brk_en = 1; trace_en = 0; to_bgd = 0;
        tick();
        pulse_cmp();   chk("R4 immediate swi", 4'b0010);
        pulse_cmp();   chk("R6 second match", 4'b0000);
        disarm();

        // R5 arm and force together
        cur_req = "R5";
        arm = 1; force_trig = 1; tick(); force_trig = 0;
        chk("R5 same write", 4'b0010);
        disarm();

        // R7 comparator masked in debug mode, R9 deferral
        cur_req = "R7";
        arm = 1; bgd_active = 1;
        tick();
        pulse_cmp();   chk("R7 cmp masked", 4'b0000);
        bgd_active = 0; tick(); chk("R7 no late brk", 4'b0000);
        cur_req = "R9";
        bgd_active = 1;
        pulse_force(); chk("R9 held while active", 4'b0000);
        tick();        chk("R9 still held", 4'b0000);
        bgd_active = 0; tick();
        chk("R9 raised after exit", 4'b0010);
        disarm();

        // R8 routing table
        cur_req = "R8";
        arm = 1; to_bgd = 1; bgd_enabled = 0; tick();
        pulse_force(); chk("R8 bgd not enabled -> swi", 4'b0010);
        disarm();
        arm = 1; to_bgd = 0; bgd_enabled = 1; tick();
        pulse_force(); chk("R8 route bit clear -> swi", 4'b0010);
        disarm();
        arm = 1; to_bgd = 1; bgd_enabled = 1; tick();
        pulse_force(); chk("R8 enabled -> bgd", 4'b0001);
        disarm();

        // R10 coincident user software interrupt
        cur_req = "R10";
        arm = 1; user_swi = 1; tick();
        pulse_force(); chk("R10 bgd wins", 4'b0001);
        disarm();
        arm = 1; to_bgd = 0; user_swi = 1; tick();
        pulse_force(); chk("R10 swi deferred", 4'b0000);
        user_swi = 0; tick();
        chk("R10 swi after", 4'b0010);
        disarm();

        // R11 disarm clears capture and pending state
        cur_req = "R11";
        arm = 1; trace_en = 1; trig_at_end = 0; tick();
        pulse_cmp();   chk("R11 capture started", 4'b1000);
        arm = 0; tick(); chk("R11 disarmed quiet", 4'b0000);
        arm = 1; buf_full = 1; tick(); buf_full = 0;
        chk("R11 capture dropped", 4'b0000);
        disarm();
        arm = 1; trace_en = 0; user_swi = 1; tick();
        pulse_force(); chk("R11 pending set", 4'b0000);
        arm = 0; tick(); user_swi = 0; tick(); arm = 1; tick();
        chk("R11 pending dropped", 4'b0000);
        tick(2);
        chk("R11 stays quiet", 4'b0000);
        disarm();

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule